// File: doc/BRIEF.md
# Output Compare Unit with Master-Channel Override

This block holds a group of output compare channels that all watch one shared timer count. A channel in compare mode tests the count against its own compare value on each cycle where the counter advances. On a match, the channel raises its event flag. It also applies a two-bit pin action to its output: hold, toggle, drive low or drive high. Software can fire the same pin action at any moment with a one-cycle force strobe, and a forced action leaves the flag untouched.

The highest-numbered channel acts as the master. A master event is either a compare hit on the master or a counter wrap that is flagged while the wrap option is on. On a master event, every other channel chosen by a mask takes its level from a data pattern. This beats whatever its own compare or force would have done in that cycle. The master compare can also ask the external counter to restart from zero. A flag clears through a write-one strobe, but only while the timer is enabled.

Top module: `ocu_master`

## Requirements
- R1: After reset every pin is low, every flag is clear and the counter-restart request is low.
- R2: A channel flag sets at the clock edge that ends a cycle in which `tick` is high, the channel's `out_mode` bit is 1 and `count` equals its compare value. With `tick` low, or `out_mode` 0, no flag sets.
- R3: The pin action code of channel i is `act_sel[2i+1:2i]`: 00 leaves the pin alone, 01 toggles it, 10 drives it low and 11 drives it high. The action applies at the same edge as the flag set.
- R4: While `pin_dis[i]` is 1, pin i keeps its level whatever the compare, force or master event.
- R5: A `force_stb[i]` pulse applies channel i's action code at the next edge, even with `tick` low, and does not set the flag.
- R6: On a master compare event (channel NCH-1), each channel i below NCH-1 with `mst_mask[i]`=1 takes `mst_data[i]`. Mask bit NCH-1 is ignored, and the master pin follows its own action code.
- R7: A cycle with `tick`, `ovf` and `mst_ovf_en` all high is a master event that applies the mask pattern without setting the master flag. With `mst_ovf_en` low, or `tick` low, an overflow has no effect.
- R8: When a master event coincides with a masked channel's own compare or force, the data bit decides that pin.
- R9: `cnt_rst` is high during any cycle with `tick` and `cnt_rst_en` high and `count` equal to the master compare value, whether or not the master is in compare mode.
- R10: `flag_clr[i]` clears flag i only while `tmr_en` is 1. A flag set in the same cycle as its clear stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Counter advances this cycle |
| count | input | CW | Current counter value |
| ovf | input | 1 | Counter wraps on this tick |
| cmp_val | input | NCH*CW | Compare values, channel i at bits [i*CW +: CW] |
| out_mode | input | NCH | 1 = channel in compare mode |
| act_sel | input | 2*NCH | Pin action code per channel |
| pin_dis | input | NCH | 1 = pin disconnected from all actions |
| force_stb | input | NCH | Forced action strobe |
| mst_mask | input | NCH | Channels overridden on a master event |
| mst_data | input | NCH | Levels applied on a master event |
| mst_ovf_en | input | 1 | Counter wrap counts as a master event |
| cnt_rst_en | input | 1 | Master compare restarts counter |
| flag_clr | input | NCH | Write-one flag clear strobe |
| tmr_en | input | 1 | Timer enabled, gates flag clears |
| pin | output | NCH | Channel pin levels |
| flag | output | NCH | Channel event flags |
| cnt_rst | output | 1 | Counter restart request |

## Verification
The bench exercises compare hits with all four action codes on channels that share one match value. This separates hold, toggle, low and high. It repeats the hit to tell a toggle from a set. Matches without a tick, or with compare mode off, show that the flag and pin depend on the tick. Forced strobes with no tick show that the action and the flag are separate. Master events stack a hit, a force and an own compare on masked and unmasked channels in one cycle, which shows which source wins. Overflow with and without the option, and the restart request with compare mode off, complete the set.

// File: rtl/ocu_master.sv
module ocu_master #(
  parameter int NCH = 8,
  parameter int CW  = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [CW-1:0]    count,
  input  logic             ovf,
  input  logic [NCH*CW-1:0] cmp_val,
  input  logic [NCH-1:0]   out_mode,
  input  logic [2*NCH-1:0] act_sel,
  input  logic [NCH-1:0]   pin_dis,
  input  logic [NCH-1:0]   force_stb,
  input  logic [NCH-1:0]   mst_mask,
  input  logic [NCH-1:0]   mst_data,
  input  logic             mst_ovf_en,
  input  logic             cnt_rst_en,
  input  logic [NCH-1:0]   flag_clr,
  input  logic             tmr_en,
  output logic [NCH-1:0]   pin,
  output logic [NCH-1:0]   flag,
  output logic             cnt_rst
);
  localparam int M = NCH - 1;
  localparam logic [NCH-1:0] MBIT = {1'b1, {(NCH-1){1'b0}}};

  logic [NCH-1:0] hit, ovr, nxt_pin;
  logic           mev;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    assign hit[i] = tick & out_mode[i] & (count == cmp_val[i*CW +: CW]);

    always_comb begin
      nxt_pin[i] = pin[i];
      if (hit[i] | force_stb[i]) begin
        case (act_sel[2*i +: 2])
          2'b01:   nxt_pin[i] = ~pin[i];
          2'b10:   nxt_pin[i] = 1'b0;
          2'b11:   nxt_pin[i] = 1'b1;
          default: nxt_pin[i] = pin[i];
        endcase
      end
      if (ovr[i])     nxt_pin[i] = mst_data[i];
      if (pin_dis[i]) nxt_pin[i] = pin[i];
    end
  end

  assign mev     = hit[M] | (tick & ovf & mst_ovf_en);
  assign ovr     = mst_mask & ~MBIT & {NCH{mev}};
  assign cnt_rst = tick & cnt_rst_en & (count == cmp_val[M*CW +: CW]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin  <= '0;
      flag <= '0;
    end else begin
      pin  <= nxt_pin;
      flag <= (flag & ~(flag_clr & {NCH{tmr_en}})) | hit;
    end
  end
endmodule

// File: rtl/ocu_master_chk.sv
module ocu_master_chk #(
  parameter int NCH = 8,
  parameter int CW  = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             ovf,
  input logic [NCH-1:0]   pin_dis,
  input logic [NCH-1:0]   force_stb,
  input logic [NCH-1:0]   mst_mask,
  input logic [NCH-1:0]   mst_data,
  input logic             mst_ovf_en,
  input logic             cnt_rst_en,
  input logic [NCH-1:0]   flag_clr,
  input logic             tmr_en,
  input logic [NCH-1:0]   pin,
  input logic [NCH-1:0]   flag,
  input logic             cnt_rst
);
  localparam logic [NCH-1:0] LOWS = {1'b0, {(NCH-1){1'b1}}};

  AST_FLAG_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> ((flag & ~$past(flag)) == '0)); // R2

  AST_DIS_PIN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((pin ^ $past(pin)) & $past(pin_dis)) == '0)); // R4

  AST_IDLE_PIN_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && force_stb == '0) |=> $stable(pin)); // R5

  AST_OVF_PATTERN: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && ovf && mst_ovf_en) |=>
      (((pin ^ $past(mst_data)) & $past(mst_mask) & ~$past(pin_dis) & LOWS) == '0)); // R7

  AST_RST_REQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_rst |-> (tick && cnt_rst_en)); // R9

  AST_CLR_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(flag) & ~flag) & ~($past(flag_clr) & {NCH{$past(tmr_en)}})) == '0)); // R10
endmodule

bind ocu_master ocu_master_chk #(.NCH(NCH), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .ovf(ovf), .pin_dis(pin_dis),
  .force_stb(force_stb), .mst_mask(mst_mask), .mst_data(mst_data),
  .mst_ovf_en(mst_ovf_en), .cnt_rst_en(cnt_rst_en), .flag_clr(flag_clr),
  .tmr_en(tmr_en), .pin(pin), .flag(flag), .cnt_rst(cnt_rst)
);

// File: tb/ocu_master_bench.sv
module ocu_master_bench;
  localparam int NCH = 8;
  localparam int CW  = 16;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic tick, ovf, mst_ovf_en, cnt_rst_en, tmr_en;
  logic [CW-1:0] count;
  logic [NCH*CW-1:0] cmp_val;
  logic [NCH-1:0] out_mode, pin_dis, force_stb, mst_mask, mst_data, flag_clr;
  logic [2*NCH-1:0] act_sel;
  logic [NCH-1:0] pin, flag;
  logic cnt_rst;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ocu_master #(.NCH(NCH), .CW(CW)) u_ocu_master (
    .clk(clk), .rst_n(rst_n), .tick(tick), .count(count), .ovf(ovf),
    .cmp_val(cmp_val), .out_mode(out_mode), .act_sel(act_sel), .pin_dis(pin_dis),
    .force_stb(force_stb), .mst_mask(mst_mask), .mst_data(mst_data),
    .mst_ovf_en(mst_ovf_en), .cnt_rst_en(cnt_rst_en), .flag_clr(flag_clr),
    .tmr_en(tmr_en), .pin(pin), .flag(flag), .cnt_rst(cnt_rst)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic set_cmp(input int ch, input logic [CW-1:0] v);
    cmp_val[ch*CW +: CW] = v;
  endtask

  task automatic set_act(input int ch, input logic [1:0] c);
    act_sel[2*ch +: 2] = c;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    tick = 0; ovf = 0; mst_ovf_en = 0; cnt_rst_en = 0; tmr_en = 1;
    count = '0; out_mode = '1; pin_dis = '0; force_stb = '0;
    mst_mask = '0; mst_data = '0; flag_clr = '0; act_sel = '0;
    for (int i = 0; i < NCH; i++) set_cmp(i, CW'(16'h1000 + i));
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 pin", 32'(pin), 0);
    check("R1 flag", 32'(flag), 0);
    check("R1 cnt_rst", 32'(cnt_rst), 0);
  endtask

  task automatic t_actions();
    do_reset();
    for (int i = 0; i < 4; i++) set_cmp(i, 16'h0040);
    set_act(0, 2'b11); set_act(1, 2'b10); set_act(2, 2'b01); set_act(3, 2'b00);
    count = 16'h0040; tick = 1;
    step();
    tick = 0;
    check("R3 codes first hit", 32'(pin[3:0]), 32'h5);
    check("R2 flags on hit", 32'(flag[3:0]), 32'hf);
    tick = 1;
    step();
    tick = 0;
    check("R3 toggle back", 32'(pin[3:0]), 32'h1);
    flag_clr = '1; step(); flag_clr = '0;
    check("R10 clear enabled", 32'(flag), 0);
    step();
    check("R2 no tick no flag", 32'(flag), 0);
    check("R2 no tick pins hold", 32'(pin[3:0]), 32'h1);
    out_mode[0] = 0; tick = 1; step(); tick = 0; out_mode[0] = 1;
    check("R2 mode off no flag", 32'(flag[0]), 0);
  endtask

  task automatic t_force();
    do_reset();
    set_act(4, 2'b11); force_stb[4] = 1; step(); force_stb = '0;
    check("R5 forced set", 32'(pin[4]), 1);
    check("R5 no flag", 32'(flag), 0);
    set_act(4, 2'b01); force_stb[4] = 1; step(); force_stb = '0;
    check("R5 forced toggle", 32'(pin[4]), 0);
  endtask

  task automatic t_disable();
    do_reset();
    set_act(5, 2'b11); pin_dis[5] = 1;
    force_stb[5] = 1; step(); force_stb = '0;
    check("R4 force blocked", 32'(pin[5]), 0);
    set_cmp(5, 16'h0077); count = 16'h0077; tick = 1; step(); tick = 0;
    check("R4 hit blocked", 32'(pin[5]), 0);
    check("R4 flag still sets", 32'(flag[5]), 1);
    mst_mask[5] = 1; mst_data[5] = 1; mst_ovf_en = 1; ovf = 1; tick = 1;
    step(); tick = 0; ovf = 0;
    check("R4 master blocked", 32'(pin[5]), 0);
  endtask

  task automatic t_master();
    do_reset();
    set_act(1, 2'b11); force_stb[1] = 1; step(); force_stb = '0;
    check("R6 pre-set ch1", 32'(pin[1]), 1);
    set_cmp(7, 16'h2000); set_act(7, 2'b11);
    set_cmp(0, 16'h2000); set_act(0, 2'b10);
    set_act(2, 2'b11);
    mst_mask = 8'b1000_0011; mst_data = 8'b0000_0001;
    cnt_rst_en = 1; count = 16'h2000; tick = 1; force_stb[2] = 1; force_stb[1] = 1;
    #1;
    check("R9 restart request", 32'(cnt_rst), 1);
    step();
    tick = 0; force_stb = '0; cnt_rst_en = 0;
    check("R6 masked ch1 takes data", 32'(pin[1]), 0);
    check("R8 data beats own clear", 32'(pin[0]), 1);
    check("R8 unmasked force acts", 32'(pin[2]), 1);
    check("R6 master own action", 32'(pin[7]), 1);
    check("R6 master flag", 32'(flag[7]), 1);
    check("R6 others untouched", 32'(pin[6:3]), 0);
  endtask

  task automatic t_overflow();
    do_reset();
    mst_mask[0] = 1; mst_data[0] = 1;
    ovf = 1; tick = 1; step();
    check("R7 option off", 32'(pin[0]), 0);
    mst_ovf_en = 1; tick = 0; step();
    check("R7 no tick", 32'(pin[0]), 0);
    tick = 1; step(); tick = 0; ovf = 0;
    check("R7 overflow override", 32'(pin[0]), 1);
    check("R7 no master flag", 32'(flag[7]), 0);
  endtask

  task automatic t_cntrst();
    do_reset();
    out_mode[7] = 0; set_act(7, 2'b11); set_cmp(7, 16'h0300);
    count = 16'h0300; cnt_rst_en = 1; tick = 1;
    #1;
    check("R9 request with mode off", 32'(cnt_rst), 1);
    step();
    check("R9 master pin idle", 32'(pin[7]), 0);
    check("R9 master flag idle", 32'(flag[7]), 0);
    cnt_rst_en = 0; #1;
    check("R9 enable low", 32'(cnt_rst), 0);
    cnt_rst_en = 1; tick = 0; #1;
    check("R9 tick low", 32'(cnt_rst), 0);
    cnt_rst_en = 0;
  endtask

  task automatic t_clear();
    do_reset();
    set_cmp(0, 16'h0010); count = 16'h0010; tick = 1; step(); tick = 0;
    check("R2 flag set", 32'(flag[0]), 1);
    tmr_en = 0; flag_clr[0] = 1; step(); flag_clr = '0;
    check("R10 clear blocked", 32'(flag[0]), 1);
    tmr_en = 1; tick = 1; flag_clr[0] = 1; step(); tick = 0; flag_clr = '0;
    check("R10 set beats clear", 32'(flag[0]), 1);
    flag_clr[0] = 1; step(); flag_clr = '0;
    check("R10 cleared", 32'(flag[0]), 0);
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    t_reset();
    t_actions();
    t_force();
    t_disable();
    t_master();
    t_overflow();
    t_cntrst();
    t_clear();
    done = 1;
    report();
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      report();
    end
  end
endmodule